// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a module clock into the 16x oversampling strobe that a UART
transmitter and receiver use, plus a bit-rate strobe that fires once per
sixteen oversample strobes. The rate is set by a 13-bit integer divisor and a
5-bit fraction counted in 1/32 steps. The effective divisor is therefore
`SBR + FRAC/32` module clocks per oversample strobe, and the bit rate is
`clk / (16 * (SBR + FRAC/32))`.

Software programs the block through a byte-wide write port with three
registers. The divisor high byte holds the top five divisor bits and two
interrupt-enable flags. The divisor low byte holds the bottom eight bits and
commits the whole divisor. The control byte holds the fraction.

The integer part sets the base length of each oversample period. A 5-bit phase
accumulator adds the fraction on every strobe. Each carry out of the
accumulator stretches that period by one clock, so over 32 strobes exactly
FRAC extra clocks are spread as evenly as the accumulator allows. New settings
are applied only at a strobe boundary, and the phase is cleared when they are
applied.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the active divisor is zero, irq_en is 0, and while the active divisor is zero neither os_tick nor bit_tick is ever asserted.
- R2: Register select on wr_addr: 0 is the divisor high byte, 1 is the divisor low byte, 2 is the control byte. The fraction is control bits [4:0]; control bits [7:5] are ignored.
- R3: A high-byte write stores data bits [4:0] as divisor bits [12:8] in a shadow only, and the running rate does not change. A low-byte write forms the 13-bit divisor {shadow, data[7:0]} and requests it as a whole.
- R4: With fraction 0 and divisor N (N >= 1), os_tick is a one-cycle pulse repeating every N clocks. N = 1 gives a pulse on every clock.
- R5: With divisor N and fraction F, every gap between strobes is N or N+1 clocks. Any 32 consecutive gaps after the settings are applied total exactly 32*N + F clocks.
- R6: bit_tick pulses only together with os_tick, on every 16th os_tick counted from the boundary where the settings were applied.
- R7: High-byte data bits [7:6] appear on irq_en right after that write. Low-byte and control writes never change irq_en.
- R8: A low-byte or control write during a running period lets that period finish at its old length. The new settings apply from the next strobe, and the phase accumulator and bit counter restart from zero at that point.
- R9: Committing a divisor of 0 stops all strobes from the next boundary onward.
- R10: A write accepted on the same clock edge that ends a strobe period does not affect the period that follows. That period runs with the old settings, and the new settings apply at the boundary after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 2 | Register select (0 high byte, 1 low byte, 2 control) |
| wr_data | input | 8 | Write data byte |
| os_tick | output | 1 | One-cycle 16x oversample strobe |
| bit_tick | output | 1 | One-cycle bit-rate strobe, coincident with os_tick |
| irq_en | output | 2 | Interrupt-enable flags held in the high byte |

## Verification
The interesting collision is a register write accepted on the same clock edge
that closes a strobe period, where the load decision and the write race for
the same state. The bench provokes this by watching for os_tick and raising
wr_en in that very cycle. It judges the result from the two following strobe
gaps: the first must keep the old length and the second must have the new one.
A separate directed case lands the write mid-period to show the old period is
not cut short. A further case starts from a known accumulator phase to show
that the phase restarts at zero when the new settings are applied.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;
    localparam int DEF_SBR_W  = 13;
    localparam int DEF_FRAC_W = 5;
    localparam int DEF_OVS    = 16;

    typedef enum logic [1:0] {
        REG_DIV_HI = 2'd0,
        REG_DIV_LO = 2'd1,
        REG_CTL    = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/fbg_regs.sv
`timescale 1ns/1ps
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int SBR_W  = DEF_SBR_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load_ack,
    output logic [SBR_W-1:0]  pend_sbr,
    output logic [FRAC_W-1:0] pend_frac,
    output logic              upd_pend,
    output logic [1:0]        irq_en
);
    localparam int HI_W = SBR_W - 8;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [1:0]        ie;
        logic [SBR_W-1:0]  sbr;
        logic [FRAC_W-1:0] frac;
        logic              upd;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_bits;

    assign unused_bits = ^wr_data;

    always_comb begin
        st_d = st_q;
        if (load_ack) begin
            st_d.upd = 1'b0;
        end
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_DIV_HI: begin
                    st_d.hi = wr_data[HI_W-1:0];
                    st_d.ie = wr_data[7:6];
                end
                REG_DIV_LO: begin
                    st_d.sbr = {st_q.hi, wr_data};
                    st_d.upd = 1'b1;
                end
                REG_CTL: begin
                    st_d.frac = wr_data[FRAC_W-1:0];
                    st_d.upd  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_sbr  = st_q.sbr;
    assign pend_frac = st_q.frac;
    assign upd_pend  = st_q.upd;
    assign irq_en    = st_q.ie;
endmodule

// File: rtl/fbg_tick.sv
`timescale 1ns/1ps
module fbg_tick
    import fbg_pkg::*;
#(
    parameter int SBR_W  = DEF_SBR_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_pend,
    input  logic [SBR_W-1:0]  pend_sbr,
    input  logic [FRAC_W-1:0] pend_frac,
    output logic              os_tick,
    output logic              load,
    output logic [SBR_W-1:0]  sbr_act
);
    localparam int CNT_W = SBR_W + 1;

    typedef struct packed {
        logic [SBR_W-1:0]  sbr;
        logic [FRAC_W-1:0] frac;
        logic [FRAC_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
    } tick_t;

    tick_t            st_d, st_q;
    logic [FRAC_W:0]  phase_sum;
    logic             stretch;
    logic [CNT_W-1:0] last_cnt;
    logic             idle;

    always_comb begin
        phase_sum = {1'b0, st_q.acc} + {1'b0, st_q.frac};
        stretch   = phase_sum[FRAC_W];
        last_cnt  = {1'b0, st_q.sbr} - CNT_W'(1) + CNT_W'(stretch);
        idle      = (st_q.sbr == '0);
        os_tick   = !idle && (st_q.cnt == last_cnt);
        load      = upd_pend && (idle || os_tick);

        st_d = st_q;
        if (load) begin
            st_d.sbr  = pend_sbr;
            st_d.frac = pend_frac;
            st_d.acc  = '0;
            st_d.cnt  = '0;
        end else if (os_tick) begin
            st_d.acc = phase_sum[FRAC_W-1:0];
            st_d.cnt = '0;
        end else if (!idle) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sbr_act = st_q.sbr;
endmodule

// File: rtl/fbg_bitdiv.sv
`timescale 1ns/1ps
module fbg_bitdiv
    import fbg_pkg::*;
#(
    parameter int OVS = DEF_OVS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic clr,
    output logic bit_tick
);
    localparam int SUB_W = $clog2(OVS);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
    } div_t;

    div_t st_d, st_q;
    logic wrap;

    always_comb begin
        wrap     = (st_q.sub == SUB_W'(OVS - 1));
        bit_tick = os_tick && wrap;
        st_d     = st_q;
        if (clr) begin
            st_d.sub = '0;
        end else if (os_tick) begin
            st_d.sub = wrap ? '0 : st_q.sub + SUB_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int SBR_W  = DEF_SBR_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int OVS    = DEF_OVS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       os_tick,
    output logic       bit_tick,
    output logic [1:0] irq_en
);
    logic [SBR_W-1:0]  pend_sbr;
    logic [FRAC_W-1:0] pend_frac;
    logic              upd_pend;
    logic              load;
    logic [SBR_W-1:0]  sbr_act;

    fbg_regs #(.SBR_W(SBR_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load_ack  (load),
        .pend_sbr  (pend_sbr),
        .pend_frac (pend_frac),
        .upd_pend  (upd_pend),
        .irq_en    (irq_en)
    );

    fbg_tick #(.SBR_W(SBR_W), .FRAC_W(FRAC_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_pend  (upd_pend),
        .pend_sbr  (pend_sbr),
        .pend_frac (pend_frac),
        .os_tick   (os_tick),
        .load      (load),
        .sbr_act   (sbr_act)
    );

    fbg_bitdiv #(.OVS(OVS)) u_bitdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .clr      (load),
        .bit_tick (bit_tick)
    );
endmodule

// File: rtl/frac_baud_gen_chk.sv
`timescale 1ns/1ps
module frac_baud_gen_chk
    import fbg_pkg::*;
#(
    parameter int SBR_W = DEF_SBR_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             os_tick,
    input logic             bit_tick,
    input logic [1:0]       irq_en,
    input logic [SBR_W-1:0] sbr_act,
    input logic             upd_pend
);
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sbr_act == '0) |-> (!os_tick && !bit_tick));

    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DIV_HI && !upd_pend) |=> $stable(sbr_act));

    assert_bit_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    assert_ie_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != REG_DIV_HI) |=> $stable(irq_en));

    assert_boundary_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sbr_act != '0 && !os_tick) |=> $stable(sbr_act));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.SBR_W(SBR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .irq_en   (irq_en),
    .sbr_act  (sbr_act),
    .upd_pend (upd_pend)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       os_tick, bit_tick;
    logic [1:0] irq_en;

    int nvec = 0;
    int nmis = 0;
    int gap = 0;
    int misalign = 0;
    int ivl[$];
    int btk[$];

    always #2.5 clk = ~clk;

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick), .irq_en(irq_en)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            gap = gap + 1;
            if (os_tick) begin
                ivl.push_back(gap);
                gap = 0;
                if (bit_tick) btk.push_back(ivl.size() - 1);
            end
            if (bit_tick && !os_tick) misalign = misalign + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nmis++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_count(input int target);
        while (ivl.size() < target) begin @(negedge clk); #1; end
    endtask

    task automatic wait_tick();
        do begin @(negedge clk); #1; end while (!os_tick);
    endtask

    task automatic settle(input int n, output int b);
        b = ivl.size();
        wait_count(b + 2 + n);
        b = b + 2;
    endtask

    task automatic check_gaps(input int b, input int n, input int s, input int f, input string req);
        int sum = 0;
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            sum += ivl[b + i];
            if (ivl[b + i] != s && ivl[b + i] != s + 1) bad++;
            if (f == 0 && ivl[b + i] != s) bad++;
        end
        chk(bad == 0, {req, " gap range"}, bad, 0);
        chk(sum == n * s + (n / 32) * f, {req, " total"}, sum, n * s + (n / 32) * f);
    endtask

    task automatic t_reset();
        chk(os_tick == 1'b0 && bit_tick == 1'b0, "R1 no strobe in reset", os_tick, 0);
        repeat (50) begin @(negedge clk); #1; end
        chk(ivl.size() == 0, "R1 idle after reset", ivl.size(), 0);
        chk(irq_en == 2'd0, "R1 irq_en reset", irq_en, 0);
    endtask

    task automatic t_max_rate();
        int b;
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h01);
        settle(40, b);
        check_gaps(b, 32, 1, 0, "R4 divisor 1");
        chk(btk.size() >= 2 && btk[btk.size()-1] - btk[btk.size()-2] == 16,
            "R6 sixteen strobes per bit", btk[btk.size()-1] - btk[btk.size()-2], 16);
    endtask

    task automatic t_integer();
        int b;
        wr(2'd1, 8'h05);
        settle(20, b);
        check_gaps(b, 20, 5, 0, "R4 divisor 5");
    endtask

    task automatic t_wide();
        int b;
        wr(2'd0, 8'h01);
        b = ivl.size();
        wait_count(b + 6);
        check_gaps(b + 1, 5, 5, 0, "R3 high write shadowed");
        wr(2'd1, 8'h03);
        settle(1, b);
        chk(ivl[b] == 259, "R3 13-bit divisor commit", ivl[b], 259);
    endtask

    task automatic t_frac();
        int b;
        wr(2'd0, 8'hC0);
        chk(irq_en == 2'd3, "R7 irq_en from high byte", irq_en, 3);
        wr(2'd1, 8'h04);
        wr(2'd2, 8'hE8);
        chk(irq_en == 2'd3, "R7 irq_en kept", irq_en, 3);
        settle(32, b);
        check_gaps(b, 32, 4, 8, "R2 R5 fraction 8 upper bits ignored");
        wr(2'd2, 8'h1F);
        settle(32, b);
        check_gaps(b, 32, 4, 31, "R5 fraction 31");
        wr(2'd1, 8'h02); wr(2'd2, 8'h01);
        settle(64, b);
        check_gaps(b, 64, 2, 1, "R5 fraction 1");
    endtask

    task automatic t_boundary();
        int b;
        wr(2'd2, 8'h00); wr(2'd1, 8'd10);
        settle(2, b);
        wait_tick();
        b = ivl.size();
        repeat (2) begin @(negedge clk); #1; end
        wr(2'd1, 8'd3);
        wait_count(b + 18);
        chk(ivl[b] == 10, "R8 old period finishes", ivl[b], 10);
        chk(ivl[b+1] == 3 && ivl[b+2] == 3, "R8 new divisor", ivl[b+1], 3);
        begin
            int first = -1;
            foreach (btk[i]) if (first < 0 && btk[i] > b) first = btk[i];
            chk(first == b + 16, "R8 bit counter restarts", first - b, 16);
        end
    endtask

    task automatic t_phase_reset();
        int b;
        wr(2'd2, 8'd16); wr(2'd1, 8'd6);
        settle(4, b);
        do wait_tick(); while (ivl[ivl.size()-1] != 7);
        b = ivl.size();
        repeat (2) begin @(negedge clk); #1; end
        wr(2'd1, 8'd4);
        wait_count(b + 3);
        chk(ivl[b] == 6, "R8 old fractional period", ivl[b], 6);
        chk(ivl[b+1] == 4 && ivl[b+2] == 5, "R8 accumulator cleared", ivl[b+1], 4);
    endtask

    task automatic t_same_edge();
        int b;
        wr(2'd2, 8'h00); wr(2'd1, 8'd10);
        settle(2, b);
        wait_tick();
        b = ivl.size();
        wr(2'd1, 8'd3);
        wait_count(b + 3);
        chk(ivl[b] == 10, "R10 write on boundary edge keeps next period", ivl[b], 10);
        chk(ivl[b+1] == 3, "R10 applied one boundary later", ivl[b+1], 3);
    endtask

    task automatic t_disable();
        int s;
        wr(2'd1, 8'h00);
        repeat (20) begin @(negedge clk); #1; end
        s = ivl.size();
        repeat (300) begin @(negedge clk); #1; end
        chk(ivl.size() == s, "R9 zero divisor stops strobes", ivl.size() - s, 0);
        chk(irq_en == 2'd3, "R7 irq_en after low write", irq_en, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nmis++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_max_rate();
        t_integer();
        t_wide();
        t_frac();
        t_boundary();
        t_phase_reset();
        t_same_edge();
        t_disable();
        chk(misalign == 0, "R6 bit strobe only with oversample strobe", misalign, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule